// File: doc/BRIEF.md
# Packet Output-Enable Controller for a Viterbi Decoder

This block sequences a packet-oriented Viterbi decoder. A one-cycle start pulse marks the cycle that carries the first codeword of a packet. In that cycle the controller latches the constraint-length mode bit and the 16-bit packet length. It then drives both values, unchanged, to the datapath modules until the next start.

A single cycle counter begins at the start pulse. The counter is compared against a fixed latency offset and against that offset plus the latched length. The result is a registered output-enable that marks the cycles in which the decoder's output bit is valid. That window begins 39 clocks after the start cycle, covering branch metrics, add-compare-select and the survivor window.

The counter stops once the window has passed and waits there. A new start restarts timing at any moment, even while an earlier packet is still draining. Reset is synchronous and active low.

Top module: `pkt_oen_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `out_en_o`=0, `mode_o`=0 and `len_o`=0, and the counter goes idle: no enable appears afterwards until a start pulse.
- R2: At a rising edge where `start_i`=1, `mode_i` and `len_i` are captured and appear on `mode_o` and `len_o` from the next cycle on.
- R3: While `start_i` is low, changes on `mode_i` and `len_i` have no effect on `mode_o` and `len_o`.
- R4: Number the start cycle 0. The first cycle with `out_en_o`=1 is cycle 39.
- R5: The counter reads n in cycle n after a start. `out_en_o` in cycle n+1 is 1 exactly when 37 < n < 37+len, which gives len-1 consecutive enabled cycles (cycles 39 to 37+len).
- R6: A captured length of 0 or 1 produces no enabled cycle.
- R7: A start pulse during a running packet forces `out_en_o` low in the next cycle, loads the new parameters, and restarts the cycle numbering of R4/R5 from that pulse.
- R8: After the window ends, the counter holds its value and `out_en_o` stays low until the next start pulse.
- R9: The counter is one bit wider than the length field. With length 65535 it does not wrap, and it yields exactly 65534 enabled cycles.
- R10: Mode encoding: `mode_i`=0 selects constraint length 4 and `mode_i`=1 selects constraint length 6. The value is passed through to `mode_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse with the first codeword of a packet |
| mode_i | input | 1 | Constraint-length select (0: K=4, 1: K=6) |
| len_i | input | 16 | Packet length in decoded bits |
| mode_o | output | 1 | Latched mode for the datapath |
| len_o | output | 16 | Latched packet length for the datapath |
| out_en_o | output | 1 | High while the decoder output bit is valid |

## Verification
Several properties are checked on every cycle:
- the latched parameters stay put between starts;
- the counter reloads on a start;
- the counter freezes once it stops;
- the counter never passes the offset-plus-length limit;
- the enable rises only when the counter sits two past the offset;
- the enable is never high for a length below two.

Other behaviour only shows up across whole packets, so the bench scenarios cover it. These include the exact 39-cycle lead and the len-1 beat count for various lengths and both modes. They also include a restart in the middle of a window, a reset in the middle of a packet, and the maximum-length packet that would overflow a 16-bit counter.

// File: rtl/pkt_oen_pkg.sv
package pkt_oen_pkg;
  typedef enum logic {
    CL_K4 = 1'b0,
    CL_K6 = 1'b1
  } cl_mode_e;
endpackage

// File: rtl/pkt_oen_param.sv
module pkt_oen_param
  import pkt_oen_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  output cl_mode_e         mode_o,
  output logic [LEN_W-1:0] len_o
);
  // Parameters are loaded only by a start pulse (R2, R10)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= CL_K4;
      len_o  <= '0;
    end else if (start_i) begin
      mode_o <= cl_mode_e'(mode_i);
      len_o  <= len_i;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(len_o) && $stable(mode_o)));
endmodule

// File: rtl/pkt_oen_counter.sv
module pkt_oen_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  // Counts from 1 after a start; stops and holds at the limit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      run_o <= 1'b0;
    end else if (start_i) begin
      cnt_o <= CNT_W'(1);
      run_o <= 1'b1;
    end else if (run_o) begin
      if (cnt_o >= limit_i) run_o <= 1'b0;
      else                  cnt_o <= cnt_o + 1'b1;
    end
  end

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_o == CNT_W'(1) && run_o));
  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !start_i) |=> ($stable(cnt_o) && !run_o));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= limit_i);
endmodule

// File: rtl/pkt_oen_window.sv
module pkt_oen_window #(
  parameter int CNT_W  = 17,
  parameter int LEN_W  = 16,
  parameter int OFFSET = 37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             out_en_o
);
  localparam logic [CNT_W-1:0] OFS = CNT_W'(OFFSET);

  logic [CNT_W-1:0] upper;
  logic             in_win;

  always_comb begin
    upper  = OFS + CNT_W'(len_i);
    in_win = (cnt_i > OFS) && (cnt_i < upper);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_en_o <= 1'b0;
    else        out_en_o <= in_win && !start_i;
  end

  assert_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> (len_i >= LEN_W'(2)));
endmodule

// File: rtl/pkt_oen_ctrl.sv
module pkt_oen_ctrl
  import pkt_oen_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int OFFSET = 37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             mode_o,
  output logic [LEN_W-1:0] len_o,
  output logic             out_en_o
);
  localparam int CNT_W = LEN_W + 1;

  cl_mode_e         mode_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             run;

  pkt_oen_param #(.LEN_W(LEN_W)) u_param (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mode_i(mode_i), .len_i(len_i), .mode_o(mode_q), .len_o(len_o)
  );

  assign limit  = CNT_W'(OFFSET) + CNT_W'(len_o);
  assign mode_o = mode_q;

  pkt_oen_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .limit_i(limit), .cnt_o(cnt), .run_o(run)
  );

  pkt_oen_window #(.CNT_W(CNT_W), .LEN_W(LEN_W), .OFFSET(OFFSET)) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cnt_i(cnt), .len_i(len_o), .out_en_o(out_en_o)
  );

  assert_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_o) |-> (cnt == CNT_W'(OFFSET + 2)));
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !out_en_o);
  assert_enable_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> (run || cnt == limit));
endmodule

// File: tb/pkt_oen_ctrl_tb_top.sv
module pkt_oen_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] len_i = '0;
  logic        mode_o;
  logic [15:0] len_o;
  logic        out_en_o;

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  pkt_oen_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .len_i(len_i), .mode_o(mode_o), .len_o(len_o), .out_en_o(out_en_o)
  );

  typedef struct packed {
    logic        m;
    logic [15:0] len;
    logic [15:0] beats;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'd2,   16'd1},
    '{1'b1, 16'd3,   16'd2},
    '{1'b0, 16'd10,  16'd9},
    '{1'b1, 16'd0,   16'd0},
    '{1'b0, 16'd1,   16'd0},
    '{1'b1, 16'd200, 16'd199}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 190000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // Pulse start, then observe ncyc cycles (cycle 1 = cycle after start)
  task automatic run_pkt(input logic m, input logic [15:0] l, input int ncyc,
                         output int first, output int beats, output int late,
                         output bit par_ok);
    @(negedge clk);
    start_i = 1'b1; mode_i = m; len_i = l;
    @(negedge clk);
    start_i = 1'b0; mode_i = ~m; len_i = ~l;
    first = 0; beats = 0; late = 0; par_ok = 1'b1;
    for (int c = 1; c <= ncyc; c++) begin
      if (c > 1) @(negedge clk);
      if (c == 20) len_i = l ^ 16'h00F0;
      if (out_en_o) begin
        if (first == 0) first = c;
        beats++;
        if (c > 37 + int'(l)) late++;
      end
      if (mode_o !== m || len_o !== l) par_ok = 1'b0;
    end
  endtask

  initial begin
    int first, beats, late;
    bit pok;

    // Reset state (R1)
    repeat (3) @(negedge clk);
    chk(out_en_o === 1'b0, "R1 reset out_en", int'(out_en_o), 0);
    chk(len_o === 16'd0 && mode_o === 1'b0, "R1 reset params", int'(len_o), 0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    chk(out_en_o === 1'b0, "R1 idle without start", int'(out_en_o), 0);

    // Vector table: lead, beat count, param capture/hold
    foreach (VECS[i]) begin
      int ebeats, efirst;
      ebeats = int'(VECS[i].beats);
      efirst = (ebeats > 0) ? 39 : 0;
      run_pkt(VECS[i].m, VECS[i].len, int'(VECS[i].len) + 60, first, beats, late, pok);
      chk(first == efirst, "R4 first enabled cycle", first, efirst);
      chk(beats == ebeats, (ebeats == 0) ? "R6 no window" : "R5 beat count", beats, ebeats);
      chk(pok, "R2/R3 params captured and held", int'(len_o), int'(VECS[i].len));
      chk(mode_o === VECS[i].m, "R10 mode passthrough", int'(mode_o), int'(VECS[i].m));
      chk(late == 0, "R8 low after window", late, 0);
    end

    // Restart during a running window (R7)
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b0; len_i = 16'd100;
    @(negedge clk);
    start_i = 1'b0;
    repeat (49) @(negedge clk);
    chk(out_en_o === 1'b1, "R5 enabled mid window", int'(out_en_o), 1);
    start_i = 1'b1; mode_i = 1'b1; len_i = 16'd5;
    @(negedge clk);
    start_i = 1'b0; mode_i = 1'b0; len_i = 16'd9;
    chk(out_en_o === 1'b0, "R7 enable drops on restart", int'(out_en_o), 1'b0);
    chk(mode_o === 1'b1 && len_o === 16'd5, "R7 new params", int'(len_o), 5);
    first = 0; beats = 0;
    for (int c = 1; c <= 80; c++) begin
      if (c > 1) @(negedge clk);
      if (out_en_o) begin
        if (first == 0) first = c;
        beats++;
      end
    end
    chk(first == 39, "R7 restarted lead", first, 39);
    chk(beats == 4, "R7 restarted beats", beats, 4);

    // Reset in the middle of a packet (R1)
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b1; len_i = 16'd50;
    @(negedge clk);
    start_i = 1'b0;
    repeat (44) @(negedge clk);
    chk(out_en_o === 1'b1, "R5 enabled before reset", int'(out_en_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_en_o === 1'b0, "R1 reset clears enable", int'(out_en_o), 0);
    chk(mode_o === 1'b0 && len_o === 16'd0, "R1 reset clears params", int'(len_o), 0);
    beats = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (out_en_o) beats++;
    end
    chk(beats == 0, "R1 counter idle after reset", beats, 0);

    // Maximum length (R9)
    run_pkt(1'b0, 16'hFFFF, 65535 + 60, first, beats, late, pok);
    chk(first == 39, "R9 max length lead", first, 39);
    chk(beats == 65534, "R9 max length beats", beats, 65534);
    chk(late == 0, "R9 no wrap after window", late, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule